// File: doc/BRIEF.md
# DMA Write-Register Byte Sequencer

This block is the programming front end of a byte-wide DMA controller. Software programs the controller by writing bytes to one port. When no parameter bytes are outstanding, a byte is a base byte. Its bit pattern names one of seven control groups. Its flag bits can ask for further parameter bytes, such as addresses, the block length, the match value and the interrupt control and vector. These parameter bytes then arrive on the same port, one per write, until the queue is empty.

Base bytes of the command group run at once. They switch the transfer enable, clear the status flags, force the ready level, reset the control fields, load the counters from the programmed addresses, or continue a transfer.

The byte stream uses a valid/ready handshake. `wr_ready` is held high in every cycle, so there is never back-pressure. A byte counts as accepted on each rising clock edge where `wr_valid` is high.

Three plain pulse inputs stand in for the transfer engine, which is outside this block. Two of them set the match and end-of-block flags. The third advances the byte count. All state is visible as registered outputs one cycle after the accepting edge.

Top module: `dmaw_seq`

## Requirements
- R1: After reset `xfer_en`=0, `irq_en`=0, `cmd`=0, `mode`=0, `param_busy`=0, both flags 0, `byte_cnt`=0 and `rdy_forced`=1.
- R2: Every accepted byte clears `xfer_en`, unless that same byte is a base byte that sets it. A byte that is ignored (unassigned base pattern `1xxxx110`, or an unlisted command) changes nothing else.
- R3: With no bytes pending (`param_busy`=0), a byte is a base byte. Otherwise it fills the next pending field and removes that field from the queue. `param_busy` is high while any field is pending.
- R4: Base patterns: `0xxxxxab` with ab≠00 is group 0; `0xxxx100` is group 1; `0xxxx000` is group 2; `1xxxxx00` is group 3; `1xxxxx01` is group 4; `1xxxx010` is group 5; `1xxxxx11` is group 6 (command).
- R5: Group 0 sets `cmd` from bits 1:0. Bits 3, 4, 5 and 6 queue the port A address low byte, port A address high byte, length low byte and length high byte.
- R6: Pending fields fill in this fixed order: A low, A high, length low, length high, match, B low, B high, interrupt control, vector. Only requested fields are taken.
- R7: Group 3 sets `irq_en` from bit 5 and `xfer_en` from bit 6. Bit 4 queues the match byte.
- R8: Group 4 sets `mode` from bits 6:5. Bits 2, 3 and 4 queue the port B address low byte, port B address high byte and interrupt control byte. An interrupt control byte with bit 4 set queues the vector byte.
- R9: Command 0x87 sets `xfer_en`. Command 0x83 clears it.
- R10: `match_hit` sets `match_flag` and `block_end` sets `end_flag`. Command 0x8B clears both.
- R11: Command 0xB3 copies bit 3 of the last group 5 byte into `rdy_forced`.
- R12: Command 0xC3 clears `cmd`, `xfer_en` and `irq_en`.
- R13: Command 0xCF reloads `mode` from the last group 4 byte and copies the port A and B addresses into `cnt_a` and `cnt_b`. It also zeroes `byte_cnt`, clears both flags and clears `xfer_en`.
- R14: Command 0xD3 zeroes `byte_cnt`, clears both flags and sets `xfer_en`. `beat` increments `byte_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Byte offered on the programming port |
| wr_ready | output | 1 | Always high; the port never stalls |
| wr_data | input | 8 | Programming byte |
| match_hit | input | 1 | Pulse that sets the match flag |
| block_end | input | 1 | Pulse that sets the end-of-block flag |
| beat | input | 1 | Pulse that increments the byte count |
| cmd | output | 2 | Transfer command field |
| mode | output | 2 | Operating mode field |
| xfer_en | output | 1 | Transfer enable |
| irq_en | output | 1 | Interrupt enable |
| rdy_forced | output | 1 | Internal ready level |
| param_busy | output | 1 | Parameter bytes pending |
| addr_a | output | 16 | Port A address |
| addr_b | output | 16 | Port B address |
| blk_len | output | 16 | Block length |
| match_val | output | 8 | Match byte |
| irq_ctrl | output | 8 | Interrupt control byte |
| irq_vec | output | 8 | Interrupt vector |
| cnt_a | output | 16 | Port A counter |
| cnt_b | output | 16 | Port B counter |
| byte_cnt | output | 16 | Byte count |
| match_flag | output | 1 | Match flag |
| end_flag | output | 1 | End-of-block flag |

## Verification
The bench sends sparse requests such as A low plus length low only. A design that filled fields by byte position rather than by request order would then put the second byte into A high. It checks that a parameter byte clears an enable that its base byte had just set, which catches a design that clears the enable only on base bytes. It checks that an interrupt control byte with bit 4 set extends the queue by a vector byte, which catches a design that ends the burst early and then decodes the vector as a base byte. It also sends an unassigned base pattern and an unlisted command, which catches a design that falls through into some other group and corrupts its fields.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  typedef enum logic [2:0] {
    GRP0 = 3'd0, GRP1 = 3'd1, GRP2 = 3'd2, GRP3 = 3'd3,
    GRP4 = 3'd4, GRP5 = 3'd5, GRP6 = 3'd6, GRP_NONE = 3'd7
  } grp_e;

  // queued parameter fields, fill order = index order
  localparam int F_ALO  = 0;
  localparam int F_AHI  = 1;
  localparam int F_LLO  = 2;
  localparam int F_LHI  = 3;
  localparam int F_MAT  = 4;
  localparam int F_BLO  = 5;
  localparam int F_BHI  = 6;
  localparam int F_ICTL = 7;
  localparam int F_VEC  = 8;
  localparam int NFLD   = 9;
  localparam int FIDX_W = $clog2(NFLD);

  localparam logic [7:0] OP_EN_OFF = 8'h83;
  localparam logic [7:0] OP_EN_ON  = 8'h87;
  localparam logic [7:0] OP_FLGCLR = 8'h8B;
  localparam logic [7:0] OP_FRCRDY = 8'hB3;
  localparam logic [7:0] OP_RESET  = 8'hC3;
  localparam logic [7:0] OP_LOAD   = 8'hCF;
  localparam logic [7:0] OP_CONT   = 8'hD3;

  typedef struct packed {
    logic en_off;
    logic en_on;
    logic flg_clr;
    logic frc_rdy;
    logic rst;
    logic load;
    logic cont;
  } act_t;
endpackage

// File: rtl/dmaw_decode.sv
module dmaw_decode
  import dmaw_pkg::*;
(
  input  logic [7:0] byte_i,
  output grp_e       grp_o
);
  always_comb begin
    grp_o = GRP_NONE;
    if (!byte_i[7]) begin
      if (byte_i[1:0] != 2'b00)       grp_o = GRP0;
      else if (byte_i[2])             grp_o = GRP1;
      else                            grp_o = GRP2;
    end else begin
      case (byte_i[1:0])
        2'b00:   grp_o = GRP3;
        2'b01:   grp_o = GRP4;
        2'b11:   grp_o = GRP6;
        default: grp_o = byte_i[2] ? GRP_NONE : GRP5;
      endcase
    end
  end
endmodule

// File: rtl/dmaw_cmd.sv
module dmaw_cmd
  import dmaw_pkg::*;
(
  input  logic       fire_i,
  input  logic [7:0] op_i,
  output act_t       act_o
);
  always_comb begin
    act_o = '0;
    if (fire_i) begin
      case (op_i)
        OP_EN_OFF: act_o.en_off  = 1'b1;
        OP_EN_ON:  act_o.en_on   = 1'b1;
        OP_FLGCLR: act_o.flg_clr = 1'b1;
        OP_FRCRDY: act_o.frc_rdy = 1'b1;
        OP_RESET:  act_o.rst     = 1'b1;
        OP_LOAD:   act_o.load    = 1'b1;
        OP_CONT:   act_o.cont    = 1'b1;
        default:   act_o         = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmaw_queue.sv
module dmaw_queue
  import dmaw_pkg::*;
#(
  parameter int N = NFLD,
  localparam int IW = (N > 1) ? $clog2(N) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [N-1:0]  req_i,
  input  logic          pop_i,
  input  logic [N-1:0]  extra_i,
  output logic          busy_o,
  output logic [N-1:0]  cur_oh_o,
  output logic [IW-1:0] cur_idx_o
);
  logic [N-1:0] pend_q;

  assign busy_o   = |pend_q;
  assign cur_oh_o = pend_q & (~pend_q + 1'b1);

  always_comb begin
    cur_idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend_q[i]) cur_idx_o = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (load_i) pend_q <= req_i;
    else if (pop_i)  pend_q <= (pend_q & ~cur_oh_o) | extra_i;
  end

  // R6
  cur_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cur_oh_o) && (busy_o == (cur_oh_o != '0)));

  // R3
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !load_i && extra_i == '0) |=>
      $countones(pend_q) == $countones($past(pend_q)) - 1);
endmodule

// File: rtl/dmaw_seq.sv
module dmaw_seq
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              match_hit,
  input  logic              block_end,
  input  logic              beat,
  output logic [1:0]        cmd,
  output logic [1:0]        mode,
  output logic              xfer_en,
  output logic              irq_en,
  output logic              rdy_forced,
  output logic              param_busy,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic [ADDR_W-1:0] blk_len,
  output logic [BYTE_W-1:0] match_val,
  output logic [BYTE_W-1:0] irq_ctrl,
  output logic [BYTE_W-1:0] irq_vec,
  output logic [ADDR_W-1:0] cnt_a,
  output logic [ADDR_W-1:0] cnt_b,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              match_flag,
  output logic              end_flag
);
  localparam int HI = ADDR_W - 1;

  grp_e             grp;
  act_t             act;
  logic             acc, base_acc, load_q, pop_q;
  logic [NFLD-1:0]  req, extra, cur_oh;
  logic [FIDX_W-1:0] cur_idx;
  logic [1:0]       g4_mode;
  logic             g5_rdy;

  assign wr_ready = 1'b1;
  assign acc      = wr_valid && wr_ready;
  assign base_acc = acc && !param_busy;

  dmaw_decode u_dec (.byte_i(wr_data), .grp_o(grp));

  dmaw_cmd u_cmd (
    .fire_i (base_acc && grp == GRP6),
    .op_i   (wr_data),
    .act_o  (act)
  );

  always_comb begin
    req = '0;
    case (grp)
      GRP0: begin
        req[F_ALO] = wr_data[3];
        req[F_AHI] = wr_data[4];
        req[F_LLO] = wr_data[5];
        req[F_LHI] = wr_data[6];
      end
      GRP3: req[F_MAT] = wr_data[4];
      GRP4: begin
        req[F_BLO]  = wr_data[2];
        req[F_BHI]  = wr_data[3];
        req[F_ICTL] = wr_data[4];
      end
      default: req = '0;
    endcase
  end

  always_comb begin
    extra = '0;
    extra[F_VEC] = (cur_idx == FIDX_W'(F_ICTL)) && wr_data[4];
  end

  assign load_q = base_acc && (req != '0);
  assign pop_q  = acc && param_busy;

  dmaw_queue #(.N(NFLD)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_q),
    .req_i    (req),
    .pop_i    (pop_q),
    .extra_i  (extra),
    .busy_o   (param_busy),
    .cur_oh_o (cur_oh),
    .cur_idx_o(cur_idx)
  );

  // register file and command effects
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0; mode <= '0; g4_mode <= '0; xfer_en <= 1'b0; irq_en <= 1'b0;
      g5_rdy <= 1'b1; rdy_forced <= 1'b1;
      addr_a <= '0; addr_b <= '0; blk_len <= '0;
      match_val <= '0; irq_ctrl <= '0; irq_vec <= '0;
      cnt_a <= '0; cnt_b <= '0;
    end else if (acc) begin
      xfer_en <= 1'b0;
      if (param_busy) begin
        case (cur_idx)
          FIDX_W'(F_ALO):  addr_a[7:0]   <= wr_data;
          FIDX_W'(F_AHI):  addr_a[HI:8]  <= wr_data[HI-8:0];
          FIDX_W'(F_LLO):  blk_len[7:0]  <= wr_data;
          FIDX_W'(F_LHI):  blk_len[HI:8] <= wr_data[HI-8:0];
          FIDX_W'(F_MAT):  match_val     <= wr_data;
          FIDX_W'(F_BLO):  addr_b[7:0]   <= wr_data;
          FIDX_W'(F_BHI):  addr_b[HI:8]  <= wr_data[HI-8:0];
          FIDX_W'(F_ICTL): irq_ctrl      <= wr_data;
          FIDX_W'(F_VEC):  irq_vec       <= wr_data;
          default: ;
        endcase
      end else begin
        case (grp)
          GRP0: cmd <= wr_data[1:0];
          GRP3: begin
            irq_en  <= wr_data[5];
            xfer_en <= wr_data[6];
          end
          GRP4: begin
            mode    <= wr_data[6:5];
            g4_mode <= wr_data[6:5];
          end
          GRP5: g5_rdy <= wr_data[3];
          default: ;
        endcase
        if (act.en_on || act.cont) xfer_en <= 1'b1;
        if (act.frc_rdy) rdy_forced <= g5_rdy;
        if (act.rst) begin
          cmd    <= '0;
          irq_en <= 1'b0;
        end
        if (act.load) begin
          mode  <= g4_mode;
          cnt_a <= addr_a;
          cnt_b <= addr_b;
        end
      end
    end
  end

  // status flags and byte count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      end_flag   <= 1'b0;
      byte_cnt   <= '0;
    end else begin
      if (act.flg_clr || act.load || act.cont) begin
        match_flag <= 1'b0;
        end_flag   <= 1'b0;
      end else begin
        if (match_hit) match_flag <= 1'b1;
        if (block_end) end_flag   <= 1'b1;
      end
      if (act.load || act.cont) byte_cnt <= '0;
      else if (beat)            byte_cnt <= byte_cnt + 1'b1;
    end
  end

  // R2
  param_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && param_busy) |=> !xfer_en);

  // R9
  en_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !param_busy && wr_data == OP_EN_ON) |=> xfer_en);

  // R12
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !param_busy && wr_data == OP_RESET) |=>
      (cmd == 2'b00 && !irq_en && !xfer_en));

  // R13
  load_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !param_busy && wr_data == OP_LOAD) |=>
      (cnt_a == $past(addr_a) && cnt_b == $past(addr_b) && byte_cnt == '0
       && !match_flag && !end_flag));
endmodule

// File: tb/dmaw_seq_tb.sv
module dmaw_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = 8'h00;
  logic        match_hit = 1'b0, block_end = 1'b0, beat = 1'b0;
  logic [1:0]  cmd, mode;
  logic        xfer_en, irq_en, rdy_forced, param_busy, match_flag, end_flag;
  logic [15:0] addr_a, addr_b, blk_len, cnt_a, cnt_b, byte_cnt;
  logic [7:0]  match_val, irq_ctrl, irq_vec;

  always #5 clk = ~clk;

  dmaw_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .match_hit(match_hit), .block_end(block_end),
    .beat(beat), .cmd(cmd), .mode(mode), .xfer_en(xfer_en), .irq_en(irq_en),
    .rdy_forced(rdy_forced), .param_busy(param_busy), .addr_a(addr_a),
    .addr_b(addr_b), .blk_len(blk_len), .match_val(match_val),
    .irq_ctrl(irq_ctrl), .irq_vec(irq_vec), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .byte_cnt(byte_cnt), .match_flag(match_flag), .end_flag(end_flag)
  );

  localparam int O_EN = 0, O_IRQ = 1, O_CMD = 2, O_MODE = 3, O_RDY = 4,
                 O_BUSY = 5, O_AA = 6, O_AB = 7, O_LEN = 8, O_MAT = 9,
                 O_ICTL = 10, O_VEC = 11, O_CA = 12, O_CB = 13, O_BC = 14,
                 O_MF = 15, O_EF = 16;

  typedef struct {
    int          sel;
    logic [15:0] val;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [15:0] peek(int sel);
    case (sel)
      O_EN:   return {15'd0, xfer_en};
      O_IRQ:  return {15'd0, irq_en};
      O_CMD:  return {14'd0, cmd};
      O_MODE: return {14'd0, mode};
      O_RDY:  return {15'd0, rdy_forced};
      O_BUSY: return {15'd0, param_busy};
      O_AA:   return addr_a;
      O_AB:   return addr_b;
      O_LEN:  return blk_len;
      O_MAT:  return {8'd0, match_val};
      O_ICTL: return {8'd0, irq_ctrl};
      O_VEC:  return {8'd0, irq_vec};
      O_CA:   return cnt_a;
      O_CB:   return cnt_b;
      O_BC:   return byte_cnt;
      O_MF:   return {15'd0, match_flag};
      default: return {15'd0, end_flag};
    endcase
  endfunction

  // monitor: compares queued expectations away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = q.pop_front();
        got = peek(it.sel);
        checks++;
        if (got !== it.val) begin
          errors++;
          $display("FAIL %s: output %0d actual %h expected %h", it.tag, it.sel, got, it.val);
        end
      end
    end
  end

  task automatic expect_o(int sel, logic [15:0] val, string tag);
    item_t it;
    it.sel = sel; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic put(logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) match_hit = 1'b1;
    else if (which == 1) block_end = 1'b1;
    else beat = 1'b1;
    @(negedge clk);
    match_hit = 1'b0; block_end = 1'b0; beat = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_o(O_EN, 0, "R1"); expect_o(O_RDY, 1, "R1"); expect_o(O_CMD, 0, "R1");
    expect_o(O_BUSY, 0, "R1"); expect_o(O_MF, 0, "R1"); expect_o(O_BC, 0, "R1");
    settle();

    // R4 R5: group 0 with all four fields
    put(8'h79);
    expect_o(O_CMD, 1, "R5"); expect_o(O_BUSY, 1, "R3");
    settle();
    put(8'h34); put(8'h12); put(8'h00);
    expect_o(O_BUSY, 1, "R3");
    settle();
    put(8'h01);
    expect_o(O_AA, 16'h1234, "R5"); expect_o(O_LEN, 16'h0100, "R5");
    expect_o(O_BUSY, 0, "R3");
    settle();

    // R6: sparse request, A low then length low
    put(8'h2A);
    expect_o(O_CMD, 2, "R5");
    settle();
    put(8'hAA); put(8'hBB);
    expect_o(O_AA, 16'h12AA, "R6"); expect_o(O_LEN, 16'h01BB, "R6");
    expect_o(O_BUSY, 0, "R6");
    settle();

    // R8: group 4 with B address, interrupt control chaining to vector
    put(8'hBD);
    expect_o(O_MODE, 1, "R8");
    settle();
    put(8'h78); put(8'h56); put(8'h10);
    expect_o(O_BUSY, 1, "R8");
    expect_o(O_AB, 16'h5678, "R8"); expect_o(O_ICTL, 8'h10, "R8");
    settle();
    put(8'h40);
    expect_o(O_VEC, 8'h40, "R8"); expect_o(O_BUSY, 0, "R8");
    settle();

    // R7 and R2: group 3 sets enable, parameter byte clears it
    put(8'hF0);
    expect_o(O_EN, 1, "R7"); expect_o(O_IRQ, 1, "R7"); expect_o(O_BUSY, 1, "R7");
    settle();
    put(8'h5A);
    expect_o(O_EN, 0, "R2"); expect_o(O_MAT, 8'h5A, "R7");
    settle();

    // R9
    put(8'h87);
    expect_o(O_EN, 1, "R9");
    settle();
    put(8'h83);
    expect_o(O_EN, 0, "R9");
    settle();

    // R2: any base byte clears enable; unassigned pattern ignored
    put(8'h87); put(8'h00);
    expect_o(O_EN, 0, "R2"); expect_o(O_BUSY, 0, "R4");
    settle();
    put(8'h87); put(8'h86);
    expect_o(O_EN, 0, "R2"); expect_o(O_CMD, 2, "R2"); expect_o(O_MODE, 1, "R2");
    expect_o(O_BUSY, 0, "R2"); expect_o(O_IRQ, 1, "R2");
    settle();
    put(8'hAB);
    expect_o(O_CMD, 2, "R2"); expect_o(O_IRQ, 1, "R2"); expect_o(O_RDY, 1, "R2");
    settle();

    // R10
    pulse(0); pulse(1);
    expect_o(O_MF, 1, "R10"); expect_o(O_EF, 1, "R10");
    settle();
    put(8'h8B);
    expect_o(O_MF, 0, "R10"); expect_o(O_EF, 0, "R10");
    settle();

    // R11: group 5 ready bit then force
    put(8'h82); put(8'hB3);
    expect_o(O_RDY, 0, "R11");
    settle();
    put(8'h8A); put(8'hB3);
    expect_o(O_RDY, 1, "R11");
    settle();

    // R13: load counters
    pulse(2); pulse(2); pulse(0);
    expect_o(O_BC, 2, "R14");
    settle();
    put(8'h87); put(8'hCF);
    expect_o(O_CA, 16'h12AA, "R13"); expect_o(O_CB, 16'h5678, "R13");
    expect_o(O_BC, 0, "R13"); expect_o(O_MF, 0, "R13"); expect_o(O_EN, 0, "R13");
    expect_o(O_MODE, 1, "R13");
    settle();

    // R14: continue
    pulse(2); pulse(1);
    expect_o(O_BC, 1, "R14"); expect_o(O_EF, 1, "R14");
    settle();
    put(8'hD3);
    expect_o(O_BC, 0, "R14"); expect_o(O_EF, 0, "R14"); expect_o(O_EN, 1, "R14");
    settle();

    // R12
    put(8'hC3);
    expect_o(O_CMD, 0, "R12"); expect_o(O_IRQ, 0, "R12"); expect_o(O_EN, 0, "R12");
    expect_o(O_AA, 16'h12AA, "R12");
    settle();

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule